// File: doc/BRIEF.md
# ADC Sample Storage With End-of-Packet Interrupt

This block sits behind an analog-to-digital converter sequencer. Converted results arrive as a packetised stream, one beat per sequencer slot. Each accepted beat is written into a register bank of 64 slot words, indexed by the slot number the beat carries. Software reads the bank, and two control words, over a simple word-addressed read/write bus.

When a beat marked as the end of a packet is accepted, a status flag is raised. Software clears the flag by writing 1 to it. An enable bit lets the flag drive the interrupt output, but the flag itself stays visible whether or not the enable is set.

The parameter `N_CONV` selects single-converter mode (1) or dual-converter mode (2); in dual mode each beat carries one result per converter. The stream never applies back-pressure: `s_ready` is high in every cycle after reset, so a beat is accepted on any clock edge where `s_valid` and `s_ready` are both high. The start-of-packet marker is accepted along with the beat and has no effect on storage or status.

Top module: `adc_sample_store`

## Requirements
- R1: An accepted beat with slot index S writes its sample(s) into the slot word at bus offset S (offsets 0x00..0x3F hold slots 1..64). A read of that offset on a later cycle returns the stored word.
- R2: In a slot word, converter-1 data (`s_data[11:0]`) sits in bits 11:0. In dual mode, converter-2 data (`s_data[23:12]`) sits in bits 27:16. All other bits read 0.
- R3: After reset, every slot word reads 0, the enable word reads 1, the status word reads 0, and `irq` is 0.
- R4: Bus writes to offsets 0x00..0x3F are ignored, and the slot contents are unchanged.
- R5: Offset 0x40 is the enable word. A write stores `bus_wdata[0]` into bit 0, and bits 31:1 read 0.
- R6: Offset 0x41 is the status word. Bit 0 becomes 1 on the clock edge that accepts a beat with `s_eop`=1, and bits 31:1 read 0.
- R7: A write of 1 in bit 0 to offset 0x41 clears the status bit. A write of 0 leaves it unchanged.
- R8: When an end-of-packet beat and a clearing write happen in the same cycle, the status bit ends up set.
- R9: `irq` is a register that takes the AND of status bit 0 and enable bit 0, so it follows them one clock later.
- R10: With enable bit 0 at 0, `irq` stays 0, while the status bit still sets and reads back as 1.
- R11: `bus_rdata` is updated one clock after a cycle with `bus_rd`=1 and holds its value between reads. Offsets 0x42..0x7F read 0.
- R12: `s_ready` is 0 during reset and 1 on every cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream ready, always high after reset |
| s_slot | input | 6 | Slot index of the beat (0 = slot 1) |
| s_data | input | 12*N_CONV | Sample data, converter 1 in the low 12 bits |
| s_sop | input | 1 | Start-of-packet marker |
| s_eop | input | 1 | End-of-packet marker |
| bus_addr | input | 7 | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq | output | 1 | End-of-packet interrupt |

## Verification
The bench targets the cycle where an end-of-packet beat meets a clearing write. A design that let the clear win would lose a packet's interrupt. It writes 0 to the status word and writes into slot offsets, which would wrongly clear the flag or overwrite stored samples in a faulty design. It masks the interrupt and then reads the status word: a design that gated the flag itself would read 0 there. It also loads all-ones samples to expose stray bits in the reserved fields, reads both end slots and unmapped offsets, and overlaps reads with stream writes to the same slot to pin down the one-cycle read timing.

// File: rtl/adc_store_pkg.sv
package adc_store_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 7;
  localparam int LANE_GAP = 16;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 7'h40;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 7'h41;

  typedef enum logic [1:0] {
    SEL_SLOT   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/sample_bank.sv
module sample_bank #(
  parameter int SLOT_CNT = 64,
  parameter int SAMP_W   = 12,
  parameter int N_CONV   = 2,
  localparam int SLOT_W  = $clog2(SLOT_CNT),
  localparam int DATA_W  = SAMP_W * N_CONV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [adc_store_pkg::WORD_W-1:0] rd_word
);
  import adc_store_pkg::*;

  logic [SAMP_W-1:0] lane_rd [N_CONV];

  for (genvar k = 0; k < N_CONV; k++) begin : g_lane
    logic [SAMP_W-1:0] mem_q [SLOT_CNT];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < SLOT_CNT; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
        mem_q[wr_slot] <= wr_data[k*SAMP_W +: SAMP_W];
      end
    end

    assign lane_rd[k] = mem_q[rd_slot];

    AST_BANK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_q[$past(wr_slot)] == $past(wr_data[k*SAMP_W +: SAMP_W])) // R1
      else $error("bank lane store mismatch");
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < N_CONV; k++) begin
      rd_word[k*LANE_GAP +: SAMP_W] = lane_rd[k];
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic eop_hit,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic stat_clr,
  output logic en_q,
  output logic stat_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      if (eop_hit)       stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
      irq_q <= stat_q & en_q;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eop_hit |=> stat_q) // R8
    else $error("status not set after end of packet");

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !eop_hit) |=> !stat_q) // R7
    else $error("status not cleared");

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr) |=> stat_q) // R7
    else $error("status dropped without clear");

  AST_MASK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_q) // R10
    else $error("irq raised while masked");
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux #(
  parameter int SLOT_CNT = 64,
  parameter int SAMP_W   = 12,
  parameter int N_CONV   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic [adc_store_pkg::ADDR_W-1:0] addr,
  input  logic [adc_store_pkg::WORD_W-1:0] bank_word,
  input  logic en_bit,
  input  logic stat_bit,
  output logic [adc_store_pkg::WORD_W-1:0] rdata_q
);
  import adc_store_pkg::*;

  rd_sel_e sel;
  logic [WORD_W-1:0] rd_next;
  logic [WORD_W-1:0] field_mask;

  always_comb begin
    if (int'(addr) < SLOT_CNT)  sel = SEL_SLOT;
    else if (addr == OFF_ENABLE) sel = SEL_ENABLE;
    else if (addr == OFF_STATUS) sel = SEL_STATUS;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_SLOT:   rd_next = bank_word;
      SEL_ENABLE: rd_next = {{(WORD_W-1){1'b0}}, en_bit};
      SEL_STATUS: rd_next = {{(WORD_W-1){1'b0}}, stat_bit};
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  always_comb begin
    field_mask = 32'h1;
    for (int k = 0; k < N_CONV; k++) field_mask[k*LANE_GAP +: SAMP_W] = '1;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_q & ~field_mask) == '0) // R2
    else $error("reserved read bits nonzero");

  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) > int'(OFF_STATUS)) |=> rdata_q == '0) // R11
    else $error("unmapped read nonzero");

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q)) // R11
    else $error("read data changed without read");
endmodule

// File: rtl/adc_sample_store.sv
module adc_sample_store #(
  parameter int SLOT_CNT = 64,
  parameter int SAMP_W   = 12,
  parameter int N_CONV   = 2,
  localparam int SLOT_W  = $clog2(SLOT_CNT),
  localparam int DATA_W  = SAMP_W * N_CONV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SLOT_W-1:0] s_slot,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_sop,
  input  logic              s_eop,
  input  logic [6:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import adc_store_pkg::*;

  logic ready_q;
  logic beat;
  logic eop_hit;
  logic en_wr;
  logic stat_clr;
  logic en_q;
  logic stat_q;
  logic [WORD_W-1:0] bank_word;
  logic [WORD_W:0]   unused_in;

  assign unused_in = {s_sop, bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign s_ready  = ready_q;
  assign beat     = s_valid & ready_q;
  assign eop_hit  = beat & s_eop;
  assign en_wr    = bus_wr && (bus_addr == OFF_ENABLE);
  assign stat_clr = bus_wr && (bus_addr == OFF_STATUS) && bus_wdata[0];

  sample_bank #(
    .SLOT_CNT (SLOT_CNT),
    .SAMP_W   (SAMP_W),
    .N_CONV   (N_CONV)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (beat),
    .wr_slot (s_slot),
    .wr_data (s_data),
    .rd_slot (bus_addr[SLOT_W-1:0]),
    .rd_word (bank_word)
  );

  irq_ctrl irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .eop_hit  (eop_hit),
    .en_wr    (en_wr),
    .en_wdata (bus_wdata[0]),
    .stat_clr (stat_clr),
    .en_q     (en_q),
    .stat_q   (stat_q),
    .irq_q    (irq)
  );

  reg_read_mux #(
    .SLOT_CNT (SLOT_CNT),
    .SAMP_W   (SAMP_W),
    .N_CONV   (N_CONV)
  ) rmux_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .bank_word (bank_word),
    .en_bit    (en_q),
    .stat_bit  (stat_q),
    .rdata_q   (bus_rdata)
  );

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready) // R12
    else $error("ready dropped");

  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(stat_q)) // R9
    else $error("irq without status");
endmodule

// File: tb/adc_sample_store_tb_top.sv
module adc_sample_store_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [5:0]  s_slot = '0;
  logic [23:0] s_data = '0;
  logic        s_sop = 1'b0;
  logic        s_eop = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_mem [64];
  logic m_en, m_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sample_store #(.N_CONV(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_slot(s_slot), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] pack_word(logic [23:0] d);
    return {4'b0, d[23:12], 4'b0, d[11:0]};
  endfunction

  function automatic logic [31:0] model_read(logic [6:0] a);
    if (a < 7'h40)  return m_mem[a[5:0]];
    if (a == 7'h40) return {31'b0, m_en};
    if (a == 7'h41) return {31'b0, m_st};
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, bit beat, logic [5:0] slot, logic [23:0] data,
                      bit eop, bit rd, logic [6:0] addr, bit wr, logic [31:0] wdata);
    logic [31:0] exp_rd;
    logic exp_irq;
    s_valid = beat; s_slot = slot; s_data = data; s_eop = eop;
    s_sop = beat && ($urandom % 4 == 0);
    bus_rd = rd; bus_addr = addr; bus_wr = wr; bus_wdata = wdata;
    exp_rd  = model_read(addr);
    exp_irq = m_st & m_en;
    if (beat) m_mem[slot] = pack_word(data);
    if (wr && addr == 7'h40) m_en = wdata[0];
    if (beat && eop) m_st = 1'b1;
    else if (wr && addr == 7'h41 && wdata[0]) m_st = 1'b0;
    @(negedge clk);
    check("R9", {31'b0, irq}, {31'b0, exp_irq});
    if (rd) check(req, bus_rdata, exp_rd);
    s_valid = 0; bus_rd = 0; bus_wr = 0; s_eop = 0; s_sop = 0;
  endtask

  task automatic rd(string req, logic [6:0] a);
    step(req, 0, 0, 0, 0, 1, a, 0, 0);
  endtask

  function automatic string tag_of(logic [6:0] a);
    if (a < 7'h40)  return "R1";
    if (a == 7'h40) return "R5";
    if (a == 7'h41) return "R6";
    return "R11";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] held;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_en = 1'b1; m_st = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", {31'b0, s_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {31'b0, s_ready}, 32'h1);
    check("R3",  {31'b0, irq}, 32'h0);
    rd("R3", 7'h00);
    rd("R3", 7'h3F);
    rd("R3", 7'h40);
    rd("R3", 7'h41);
    rd("R11", 7'h55);
    rd("R11", 7'h7F);

    // R1 / R2: end slots, all-ones data exposes reserved bits
    step("R1", 1, 6'd0, 24'hFFFFFF, 0, 0, 0, 0, 0);
    step("R1", 1, 6'd63, 24'hABC123, 0, 0, 0, 0, 0);
    rd("R2", 7'h00);
    check("R2", bus_rdata, 32'h0FFF0FFF);
    rd("R1", 7'h3F);
    check("R2", bus_rdata, 32'h0ABC0123);

    // R4: writes to slot offsets are ignored
    step("R4", 0, 0, 0, 0, 0, 7'h00, 1, 32'h12345678);
    rd("R4", 7'h00);

    // R11: read data holds between reads
    held = bus_rdata;
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    check("R11", bus_rdata, held);

    // R6 / R9: end of packet sets status, irq one cycle later
    step("R6", 1, 6'd5, 24'h111222, 1, 0, 0, 0, 0);
    check("R6", {31'b0, irq}, 32'h0);
    rd("R6", 7'h41);
    check("R9", {31'b0, irq}, 32'h1);

    // R7: write 0 has no effect, write 1 clears
    step("R7", 0, 0, 0, 0, 0, 7'h41, 1, 32'hFFFFFFFE);
    rd("R7", 7'h41);
    step("R7", 0, 0, 0, 0, 0, 7'h41, 1, 32'h1);
    rd("R7", 7'h41);
    rd("R7", 7'h41);

    // R8: set and clear in the same cycle
    step("R8", 1, 6'd9, 24'h0F0F0F, 1, 0, 7'h41, 1, 32'h1);
    rd("R8", 7'h41);
    check("R8", bus_rdata, 32'h1);
    step("R7", 0, 0, 0, 0, 0, 7'h41, 1, 32'h1);

    // R5 / R10: mask irq, status still visible
    step("R5", 0, 0, 0, 0, 0, 7'h40, 1, 32'hFFFFFFFE);
    rd("R5", 7'h40);
    step("R10", 1, 6'd2, 24'h000777, 1, 0, 0, 0, 0);
    rd("R10", 7'h41);
    check("R10", bus_rdata, 32'h1);
    check("R10", {31'b0, irq}, 32'h0);
    step("R5", 0, 0, 0, 0, 0, 7'h40, 1, 32'hFFFFFFFF);
    rd("R5", 7'h40);
    rd("R9", 7'h41);

    // R1: read and stream write to the same slot in one cycle
    step("R1", 1, 6'd9, 24'h555AAA, 0, 1, 7'h09, 0, 0);
    rd("R1", 7'h09);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      bit b, e, r, w;
      logic [6:0] a;
      logic [31:0] wd;
      b = ($urandom % 10) < 6;
      e = ($urandom % 16) == 0;
      r = ($urandom % 2) == 1;
      w = ($urandom % 10) == 0;
      a = 7'($urandom % 72);
      if (w && ($urandom % 2 == 1)) a = 7'h40 + 7'($urandom % 2);
      wd = $urandom;
      if (a == 7'h40 && w) wd[0] = ($urandom % 4) != 0;
      step(tag_of(a), b, 6'($urandom), 24'($urandom), e, r, a, w, wd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule